// File: doc/BRIEF.md
# Ripple-Chain Fall-Through FIFO

This block is an elastic buffer built as a chain of storage positions, each with its own occupancy flag. A word written at the head of the chain drifts toward the tail one position per clock while the next position is empty. Vacancies drift the opposite way. A consumer therefore sees the oldest word at the tail as soon as it has arrived, with no read or write pointers anywhere in the design.

The producer and consumer each drive a strobe that is not tied to the block clock. Both strobes are synchronized and reduced to single-cycle events. A word is taken in on the rising edge of the write strobe. The tail word is released on the falling edge of the read strobe. A head flag tells the producer whether there is room, and a tail flag tells the consumer whether a word is waiting.

A master reset marks every position empty but leaves the stored bits as they were. The output is modelled as a data bus plus a drive-enable bit. The bus can be released at any time without any effect on the buffer's contents.

Top module: `ripple_fifo`

## Requirements
- R1: While master reset `mr` is high and right after it, `dout_ready` is 0 and `din_ready` is 1.
- R2: A rising edge of `shift_in` while `din_ready` is 1 stores `din`. Words leave at `dout` in the order they were stored, and the occupied-position count changes by exactly (loads minus unloads) each clock.
- R3: `din_ready` is the inverse of the head position's flag. It drops in the clock after a load, and it stays 0 while all DEPTH positions are full. A `shift_in` edge while it is 0 stores nothing.
- R4: Holding `shift_in` high stores exactly one word. `shift_in` must return to 0 before another word is accepted.
- R5: A falling edge of `shift_out` while `dout_ready` is 1 removes the tail word. `dout_ready` is 0 in the following clock and returns to 1 when the next word arrives.
- R6: A falling edge of `shift_out` while `dout_ready` is 0 has no effect.
- R7: Master reset empties every position and leaves the stored data bits, and so the value on `dout`, unchanged.
- R8: If `shift_in` is held high through master reset, the word on `din` is stored once reset ends.
- R9: `dout_drive` is the inverse of `out_disable`. Changing `out_disable` never alters the stored words or the order in which they leave.
- R10: A position becomes filled only if its upstream neighbour was filled in the previous clock. A word entering an empty buffer reaches the tail DEPTH-1 clocks after `din_ready` falls. While `dout_ready` stays 0, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mr | input | 1 | Master reset, active high, clears occupancy flags only |
| shift_in | input | 1 | Asynchronous write strobe, a word is taken on its rising edge |
| shift_out | input | 1 | Asynchronous read strobe, the tail word is released on its falling edge |
| din | input | WIDTH | Word to be written |
| out_disable | input | 1 | High releases the output bus |
| din_ready | output | 1 | Head position vacant |
| dout_ready | output | 1 | Tail position holds a word |
| dout | output | WIDTH | Tail word |
| dout_drive | output | 1 | Output bus drive enable |

## Verification
The bench uses the default build: 16 positions of 4 bits and two synchronizer stages. At this size the buffer can be filled to the last slot and drained again in full. This covers the full-buffer refusal, the one-step-per-clock bubble travel back to the head, and the exact 15-clock trip from head to tail. The strobes are held long enough for the synchronizer edges to be unambiguous, so each load and unload happens in a cycle that can be counted.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

  // A position takes the upstream word when it is vacant and upstream is filled.
  function automatic logic take_word(input logic self_filled, input logic up_filled);
    return up_filled & ~self_filled;
  endfunction

  // Next flag of a position given its own take and the downstream take.
  function automatic logic next_flag(input logic cur, input logic taking, input logic given);
    if (taking) return 1'b1;
    if (given) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/ripple_strobe_sync.sv
module ripple_strobe_sync #(
  parameter int STAGES = 2,
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic mr,
  input  logic async_in,
  output logic pulse
);
  logic [STAGES-1:0] stg_q;
  logic              last_q;
  logic              level;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      stg_q  <= '0;
      last_q <= 1'b0;
    end else begin
      stg_q  <= {stg_q[STAGES-2:0], async_in};
      last_q <= stg_q[STAGES-1];
    end
  end

  assign level = stg_q[STAGES-1];

  generate
    if (RISING) begin : g_rise
      assign pulse = level & ~last_q;
    end else begin : g_fall
      assign pulse = ~level & last_q;
    end
  endgenerate
endmodule

// File: rtl/ripple_cell.sv
module ripple_cell
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             up_filled,
  input  logic [WIDTH-1:0] up_data,
  input  logic             down_take,
  output logic             filled,
  output logic             take,
  output logic [WIDTH-1:0] data
);
  logic             flag_q;
  logic [WIDTH-1:0] data_q;

  assign take = take_word(flag_q, up_filled);

  always_ff @(posedge clk or posedge mr) begin
    if (mr) flag_q <= 1'b0;
    else    flag_q <= next_flag(flag_q, take, down_take);
  end

  // Stored bits have no reset: master reset only declares them invalid.
  always_ff @(posedge clk) begin
    if (take) data_q <= up_data;
  end

  assign filled = flag_q;
  assign data   = data_q;
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int DEPTH       = 16,
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic [WIDTH-1:0] din,
  input  logic             out_disable,
  output logic             din_ready,
  output logic             dout_ready,
  output logic [WIDTH-1:0] dout,
  output logic             dout_drive
);
  localparam int LAST = DEPTH - 1;

  logic             in_rise;
  logic             out_fall;
  logic             load_evt;
  logic             unload_evt;
  logic [DEPTH-1:0] marks;
  logic [DEPTH-1:0] takes;
  logic [WIDTH-1:0] cell_data [DEPTH];

  ripple_strobe_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_in_sync (
    .clk(clk), .mr(mr), .async_in(shift_in), .pulse(in_rise)
  );

  ripple_strobe_sync #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_out_sync (
    .clk(clk), .mr(mr), .async_in(shift_out), .pulse(out_fall)
  );

  assign din_ready  = ~marks[0];
  assign dout_ready = marks[LAST];
  assign load_evt   = in_rise & din_ready;
  assign unload_evt = out_fall & dout_ready;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_pos
      logic             up_f;
      logic [WIDTH-1:0] up_d;
      logic             dn_t;
      if (i == 0) begin : g_head
        assign up_f = load_evt;
        assign up_d = din;
      end else begin : g_body
        assign up_f = marks[i-1];
        assign up_d = cell_data[i-1];
      end
      if (i == LAST) begin : g_tail
        assign dn_t = unload_evt;
      end else begin : g_inner
        assign dn_t = takes[i+1];
      end
      ripple_cell #(.WIDTH(WIDTH)) u_cell (
        .clk(clk), .mr(mr),
        .up_filled(up_f), .up_data(up_d), .down_take(dn_t),
        .filled(marks[i]), .take(takes[i]), .data(cell_data[i])
      );
    end
  endgenerate

  assign dout       = cell_data[LAST];
  assign dout_drive = ~out_disable;
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             mr,
  input logic             din_ready,
  input logic             dout_ready,
  input logic [WIDTH-1:0] dout,
  input logic             load_evt,
  input logic             unload_evt,
  input logic [DEPTH-1:0] marks
);
  always @(posedge clk) begin
    if (mr) assert_reset_flags_R1: assert (!dout_ready && din_ready);
  end

  assert_load_gated_R3: assert property (@(posedge clk) disable iff (mr)
    load_evt |-> din_ready);

  assert_head_busy_after_load_R3: assert property (@(posedge clk) disable iff (mr)
    load_evt |=> !din_ready);

  assert_unload_gated_R6: assert property (@(posedge clk) disable iff (mr)
    unload_evt |-> dout_ready);

  assert_tail_drop_R5: assert property (@(posedge clk) disable iff (mr)
    unload_evt |=> !dout_ready);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (mr)
    int'($countones(marks)) ==
      int'($countones($past(marks))) + int'($past(load_evt)) - int'($past(unload_evt)));

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (mr)
    (!dout_ready && $past(!dout_ready)) |-> $stable(dout));

  assert_head_fill_R10: assert property (@(posedge clk) disable iff (mr)
    $rose(marks[0]) |-> $past(load_evt));

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_step
      assert_one_step_R10: assert property (@(posedge clk) disable iff (mr)
        $rose(marks[i]) |-> $past(marks[i-1]));
    end
  endgenerate
endmodule

bind ripple_fifo ripple_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .mr(mr), .din_ready(din_ready), .dout_ready(dout_ready),
  .dout(dout), .load_evt(load_evt), .unload_evt(unload_evt), .marks(marks)
);

// File: tb/ripple_fifo_tb_top.sv
`timescale 1ns/1ps
module ripple_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic mr = 1'b1;
  logic shift_in = 1'b0;
  logic shift_out = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic out_disable = 1'b0;
  logic din_ready, dout_ready, dout_drive;
  logic [WIDTH-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .mr(mr), .shift_in(shift_in), .shift_out(shift_out), .din(din),
    .out_disable(out_disable), .din_ready(din_ready), .dout_ready(dout_ready),
    .dout(dout), .dout_drive(dout_drive)
  );

  // bit4 = 1 push data, bit4 = 0 pop and expect data
  localparam logic [4:0] VEC [0:7] = '{5'h1A, 5'h1B, 5'h1C, 5'h0A, 5'h1D, 5'h0B, 5'h0C, 5'h0D};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [WIDTH-1:0] d);
    @(negedge clk);
    din = d;
    shift_in = 1'b1;
    idle(6);
    shift_in = 1'b0;
    idle(6);
  endtask

  task automatic pulse_out();
    @(negedge clk);
    shift_out = 1'b1;
    idle(6);
    shift_out = 1'b0;
    idle(6);
  endtask

  task automatic wait_out();
    for (int i = 0; i < 40 && !dout_ready; i++) @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input logic [WIDTH-1:0] exp);
    wait_out();
    chk({req, " ready"}, int'(dout_ready), 1);
    chk({req, " data"}, int'(dout), int'(exp));
    pulse_out();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    logic head_back;
    idle(3);
    // R1 reset state
    chk("R1 dout_ready in reset", int'(dout_ready), 0);
    chk("R1 din_ready in reset", int'(din_ready), 1);
    mr = 1'b0;
    idle(3);
    chk("R1 dout_ready after reset", int'(dout_ready), 0);
    chk("R1 din_ready after reset", int'(din_ready), 1);

    // R2 R5 vector table
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][4]) push(VEC[v][3:0]);
      else pop_expect("R2 R5 table", VEC[v][3:0]);
    end
    idle(30);
    chk("R2 empty after table", int'(dout_ready), 0);

    // R10 ripple timing and brief head-busy (R3)
    @(negedge clk);
    din = 4'h7;
    shift_in = 1'b1;
    for (int i = 0; i < 20 && din_ready; i++) @(negedge clk);
    @(negedge clk);
    head_back = din_ready;
    cnt = 1;
    for (int i = 0; i < 40 && !dout_ready; i++) begin
      @(negedge clk);
      cnt++;
    end
    chk("R3 head ready one clock after load", int'(head_back), 1);
    chk("R10 head to tail clocks", cnt, DEPTH - 1);
    chk("R10 data at tail", int'(dout), 7);
    shift_in = 1'b0;
    idle(4);
    chk("R4 single word while held", int'(dout_ready), 1);

    // R5 drop in clock after unload with more data behind
    push(4'h8);
    idle(20);
    @(negedge clk);
    shift_out = 1'b1;
    idle(4);
    shift_out = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10 && dout_ready; i++) begin
      @(negedge clk);
      cnt++;
    end
    chk("R5 ready drops after unload", int'(dout_ready), 0);
    @(negedge clk);
    chk("R5 ready returns", int'(dout_ready), 1);
    chk("R5 next word", int'(dout), 8);
    idle(4);
    pulse_out();
    idle(5);
    chk("R5 empty", int'(dout_ready), 0);

    // R3 fill to full, extra strobe refused
    for (int k = 0; k < DEPTH; k++) push(WIDTH'(k));
    idle(25);
    chk("R3 full din_ready", int'(din_ready), 0);
    push(4'hF);
    for (int k = 0; k < DEPTH; k++) pop_expect("R3 drain order", WIDTH'(k));
    idle(30);
    chk("R3 extra word not stored", int'(dout_ready), 0);
    chk("R3 head free after drain", int'(din_ready), 1);

    // R4 long high strobe stores one word
    @(negedge clk);
    din = 4'h6;
    shift_in = 1'b1;
    idle(40);
    shift_in = 1'b0;
    pop_expect("R4 held word", 4'h6);
    idle(30);
    chk("R4 only one word", int'(dout_ready), 0);

    // R6 unload strobes on empty
    pulse_out();
    pulse_out();
    push(4'h3);
    push(4'h4);
    pop_expect("R6 first after empty strobes", 4'h3);
    pop_expect("R6 second after empty strobes", 4'h4);
    idle(30);
    chk("R6 empty again", int'(dout_ready), 0);

    // R9 output disable independent of shifting
    push(4'h9);
    push(4'h2);
    idle(30);
    out_disable = 1'b1;
    @(negedge clk);
    chk("R9 drive off", int'(dout_drive), 0);
    pulse_out();
    out_disable = 1'b0;
    @(negedge clk);
    chk("R9 drive on", int'(dout_drive), 1);
    pop_expect("R9 word after disabled unload", 4'h2);
    idle(30);
    chk("R9 empty", int'(dout_ready), 0);

    // R7 reset keeps data bits
    push(4'h5);
    idle(30);
    chk("R7 word present", int'(dout), 5);
    @(negedge clk);
    mr = 1'b1;
    idle(2);
    mr = 1'b0;
    idle(30);
    chk("R7 dout_ready cleared", int'(dout_ready), 0);
    chk("R7 din_ready set", int'(din_ready), 1);
    chk("R7 data unchanged", int'(dout), 5);
    chk("R10 bus holds while empty", int'(dout), 5);

    // R8 shift_in high through reset
    @(negedge clk);
    mr = 1'b1;
    din = 4'hA;
    shift_in = 1'b1;
    idle(3);
    mr = 1'b0;
    idle(30);
    chk("R8 word loaded after reset", int'(dout_ready), 1);
    chk("R8 data", int'(dout), 10);
    shift_in = 1'b0;
    pulse_out();
    idle(30);
    chk("R8 single word", int'(dout_ready), 0);

    finish_run();
  end
endmodule